// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block is the per-processor front end of an interrupt controller. The distributor side presents a single candidate: the pending interrupt with the highest priority, given as an ID and an 8-bit priority value. The block compares that candidate with a programmable threshold and with its own enable bit, and drives an interrupt request line to the processor.

Software controls the block through a 32-bit register port. Reading the acknowledge register claims the interrupt that currently qualifies and returns its ID. The claimed interrupt becomes active, and the block tells the distributor so with a one-cycle strobe. If nothing qualifies, the read returns the spurious ID. Writing the ID of the active interrupt to the end-of-interrupt register retires it, and the block reports that completion to the distributor with another strobe.

There is no preemption. At most one interrupt is active at a time, and while it is active no other interrupt is signalled or claimed.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the enable bit is 0, the priority threshold is 0, the request line is low, and an acknowledge read returns ID 1023.
- R2: Bit 0 of the control register (offset 0x000) is the forwarding enable. Writing the register stores bit 0 only, and a read returns that bit with all upper bits 0.
- R3: The priority threshold register (offset 0x004) keeps the low 8 bits of a write and returns them on read, with the upper bits 0.
- R4: The request line is high in the cycle after the following conditions all hold, and low otherwise: enable is 1, the distributor presents a valid candidate, the candidate's priority is numerically less than the threshold (a priority equal to the threshold does not qualify), and no interrupt is active.
- R5: A read of the acknowledge register (offset 0x00C) while a candidate qualifies has three effects. It returns the candidate ID in bits [9:0] with the upper bits 0. It raises the ack strobe for one cycle, carrying that ID. It makes the ID the active interrupt.
- R6: An acknowledge read while nothing qualifies returns 1023, raises no ack strobe and changes no state.
- R7: While an interrupt is active, the request line stays low and an acknowledge read returns 1023, even if a candidate with a better priority is pending.
- R8: A write to the end-of-interrupt register (offset 0x010) whose bits [9:0] equal the active ID raises the EOI strobe for one cycle, carrying that ID, and ends the active state. A qualifying candidate then drives the request line high again.
- R9: An end-of-interrupt write with an ID that is not active, or made while nothing is active, raises no strobe and leaves the active interrupt in place.
- R10: The following reads return 0: the end-of-interrupt offset and any unmapped offset. A write to the acknowledge offset changes nothing.
- R11: Read data is valid, with read-valid high, exactly one cycle after a read request. Read-valid stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| pend_valid | input | 1 | Distributor presents a candidate |
| pend_id | input | ID_W | Candidate interrupt ID |
| pend_prio | input | PRIO_W | Candidate priority, lower value is more urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_stb | output | 1 | One-cycle strobe: candidate claimed |
| ack_id | output | ID_W | ID carried by ack_stb |
| eoi_stb | output | 1 | One-cycle strobe: active interrupt retired |
| eoi_id | output | ID_W | ID carried by eoi_stb |

## Verification
The assertions assume two things about the inputs. First, at most one register access arrives per cycle. Second, the distributor may keep presenting a claimed candidate for a few cycles after the ack strobe, and it never presents the spurious ID as a real candidate. The stimulus follows both assumptions: it issues one access at a time, uses IDs below 1023, and drops or replaces the candidate only after an acknowledge has completed.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
   localparam int unsigned OFS_CTRL = 32'h000;
   localparam int unsigned OFS_MASK = 32'h004;
   localparam int unsigned OFS_ACK  = 32'h00C;
   localparam int unsigned OFS_EOI  = 32'h010;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_MASK,
      SEL_ACK,
      SEL_EOI
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [31:0] a);
      case (a)
         OFS_CTRL: return SEL_CTRL;
         OFS_MASK: return SEL_MASK;
         OFS_ACK:  return SEL_ACK;
         OFS_EOI:  return SEL_EOI;
         default:  return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_cif_regs.sv
module irq_cif_regs
   import irq_cif_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8,
   parameter int ID_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [ID_W-1:0]   ack_data,
   output logic              en_o,
   output logic [PRIO_W-1:0] mask_o,
   output logic              ack_rd_o,
   output logic              eoi_wr_o,
   output logic [ID_W-1:0]   eoi_id_o,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   reg_sel_e          sel;
   logic              is_rd;
   logic              is_wr;
   logic [DATA_W-1:0] rd_mux;

   assign sel      = decode_ofs(32'(req_addr));
   assign is_rd    = req_valid && !req_write;
   assign is_wr    = req_valid && req_write;
   assign ack_rd_o = is_rd && (sel == SEL_ACK);
   assign eoi_wr_o = is_wr && (sel == SEL_EOI);
   assign eoi_id_o = req_wdata[ID_W-1:0];

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_CTRL: rd_mux[0]          = en_o;
         SEL_MASK: rd_mux[PRIO_W-1:0] = mask_o;
         SEL_ACK:  rd_mux[ID_W-1:0]   = ack_data;
         default:  rd_mux             = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o     <= 1'b0;
         mask_o   <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (is_wr && sel == SEL_CTRL) en_o   <= req_wdata[0];
         if (is_wr && sel == SEL_MASK) mask_o <= req_wdata[PRIO_W-1:0];
         rd_valid <= is_rd;
         rd_data  <= is_rd ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/irq_cif_gate.sv
module irq_cif_gate #(
   parameter int PRIO_W  = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [PRIO_W-1:0] mask,
   input  logic              pend_valid,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic              busy,
   input  logic              take,
   output logic              qual_o,
   output logic              irq_o
);
   assign qual_o = enable && pend_valid && (pend_prio < mask) && !busy;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= qual_o && !take;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = qual_o;
      end
   endgenerate
endmodule

// File: rtl/irq_cif_active.sv
module irq_cif_active #(
   parameter int ID_W        = 10,
   parameter int SPURIOUS_ID = 1023
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            qual,
   input  logic            ack_rd,
   input  logic [ID_W-1:0] pend_id,
   input  logic            eoi_wr,
   input  logic [ID_W-1:0] eoi_id_in,
   output logic            busy_o,
   output logic            take_o,
   output logic [ID_W-1:0] ack_data_o,
   output logic            ack_stb,
   output logic [ID_W-1:0] ack_id,
   output logic            eoi_stb,
   output logic [ID_W-1:0] eoi_id
);
   localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

   logic            act_v;
   logic [ID_W-1:0] act_id;
   logic            retire;

   assign busy_o     = act_v;
   assign take_o     = ack_rd && qual;
   assign ack_data_o = take_o ? pend_id : SPUR;
   assign retire     = eoi_wr && act_v && (eoi_id_in == act_id);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_v   <= 1'b0;
         act_id  <= '0;
         ack_stb <= 1'b0;
         ack_id  <= '0;
         eoi_stb <= 1'b0;
         eoi_id  <= '0;
      end else begin
         if (take_o) begin
            act_v  <= 1'b1;
            act_id <= pend_id;
         end else if (retire) begin
            act_v  <= 1'b0;
         end
         ack_stb <= take_o;
         if (take_o) ack_id <= pend_id;
         eoi_stb <= retire;
         if (retire) eoi_id <= eoi_id_in;
      end
   end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int PRIO_W      = 8,
   parameter int ID_W        = 10,
   parameter int SPURIOUS_ID = 1023,
   parameter bit IRQ_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pend_valid,
   input  logic [ID_W-1:0]   pend_id,
   input  logic [PRIO_W-1:0] pend_prio,
   output logic              irq_o,
   output logic              ack_stb,
   output logic [ID_W-1:0]   ack_id,
   output logic              eoi_stb,
   output logic [ID_W-1:0]   eoi_id
);
   localparam longint ID_SPAN = longint'(1) << ID_W;

   generate
      if (ADDR_W < 5 || ADDR_W > 31) begin : g_bad_addr
         $error("irq_cpu_if: ADDR_W must lie in 5..31");
      end
      if (DATA_W < ID_W || DATA_W < PRIO_W) begin : g_bad_data
         $error("irq_cpu_if: DATA_W narrower than ID or priority field");
      end
      if (longint'(SPURIOUS_ID) >= ID_SPAN) begin : g_bad_spur
         $error("irq_cpu_if: SPURIOUS_ID does not fit ID_W");
      end
   endgenerate

   logic              en;
   logic [PRIO_W-1:0] mask;
   logic              ack_rd;
   logic              eoi_wr;
   logic [ID_W-1:0]   eoi_wid;
   logic [ID_W-1:0]   ack_data;
   logic              qual;
   logic              busy;
   logic              take;

   irq_cif_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ID_W(ID_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .ack_data(ack_data),
      .en_o(en), .mask_o(mask),
      .ack_rd_o(ack_rd), .eoi_wr_o(eoi_wr), .eoi_id_o(eoi_wid),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   irq_cif_gate #(
      .PRIO_W(PRIO_W), .IRQ_REG(IRQ_REG)
   ) u_gate (
      .clk(clk), .rst_n(rst_n),
      .enable(en), .mask(mask),
      .pend_valid(pend_valid), .pend_prio(pend_prio),
      .busy(busy), .take(take),
      .qual_o(qual), .irq_o(irq_o)
   );

   irq_cif_active #(
      .ID_W(ID_W), .SPURIOUS_ID(SPURIOUS_ID)
   ) u_active (
      .clk(clk), .rst_n(rst_n),
      .qual(qual), .ack_rd(ack_rd), .pend_id(pend_id),
      .eoi_wr(eoi_wr), .eoi_id_in(eoi_wid),
      .busy_o(busy), .take_o(take), .ack_data_o(ack_data),
      .ack_stb(ack_stb), .ack_id(ack_id),
      .eoi_stb(eoi_stb), .eoi_id(eoi_id)
   );
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int ID_W        = 10,
   parameter int SPURIOUS_ID = 1023,
   parameter bit IRQ_REG     = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              pend_valid,
   input logic              irq_o,
   input logic              ack_stb,
   input logic [ID_W-1:0]   ack_id,
   input logic              eoi_stb
);
   localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(irq_cif_pkg::OFS_EOI);
   localparam logic [ID_W-1:0]   SPUR  = ID_W'(SPURIOUS_ID);

   AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid); // R11
   AST_RD_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write)); // R11
   AST_ACK_RETURNS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |-> (rd_valid && rd_data[ID_W-1:0] == ack_id && ack_id != SPUR)); // R5
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack_stb, eoi_stb})); // R8
   AST_EOI_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_stb |-> $past(req_valid && req_write && req_addr == A_EOI)); // R9

   generate
      if (IRQ_REG) begin : g_reg_props
         AST_NO_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            ack_stb |-> !irq_o); // R7
         AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(pend_valid)); // R4
      end
   endgenerate
endmodule

bind irq_cpu_if irq_cpu_if_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
   .SPURIOUS_ID(SPURIOUS_ID), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
   .rd_valid(rd_valid), .rd_data(rd_data),
   .pend_valid(pend_valid), .irq_o(irq_o),
   .ack_stb(ack_stb), .ack_id(ack_id), .eoi_stb(eoi_stb)
);

// File: tb/irq_cpu_if_tb.sv
`timescale 1ns/1ps
module irq_cpu_if_tb;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int IW = 10;
   localparam int PW = 8;
   localparam logic [AW-1:0] A_CTRL = 12'h000;
   localparam logic [AW-1:0] A_MASK = 12'h004;
   localparam logic [AW-1:0] A_ACK  = 12'h00C;
   localparam logic [AW-1:0] A_EOI  = 12'h010;
   localparam logic [31:0]   SPUR   = 32'd1023;

   // vector: {enable, threshold, cand_valid, cand_prio, cand_id, expect_irq}
   localparam int NV = 8;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1, 8'h80, 1'b1, 8'h10, 10'd40,   1'b1},
      {1'b0, 8'h80, 1'b1, 8'h10, 10'd41,   1'b0},
      {1'b1, 8'h80, 1'b1, 8'h80, 10'd42,   1'b0},
      {1'b1, 8'h80, 1'b1, 8'h7F, 10'd43,   1'b1},
      {1'b1, 8'hFF, 1'b1, 8'hFE, 10'd1022, 1'b1},
      {1'b1, 8'h00, 1'b1, 8'h00, 10'd5,    1'b0},
      {1'b1, 8'hFF, 1'b0, 8'h00, 10'd7,    1'b0},
      {1'b1, 8'h20, 1'b1, 8'h1F, 10'd0,    1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          pend_valid = 1'b0;
   logic [IW-1:0] pend_id = '0;
   logic [PW-1:0] pend_prio = '0;
   logic          irq_o;
   logic          ack_stb;
   logic [IW-1:0] ack_id;
   logic          eoi_stb;
   logic [IW-1:0] eoi_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic          c_rdv;
   logic [DW-1:0] c_rdata;
   logic          c_ack;
   logic [IW-1:0] c_ack_id;
   logic          c_eoi;
   logic [IW-1:0] c_eoi_id;

   always #5 clk = ~clk;

   irq_cpu_if u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .pend_valid(pend_valid), .pend_id(pend_id), .pend_prio(pend_prio),
      .irq_o(irq_o),
      .ack_stb(ack_stb), .ack_id(ack_id),
      .eoi_stb(eoi_stb), .eoi_id(eoi_id)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the access edge
   task automatic bus(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      c_rdv    = rd_valid;
      c_rdata  = rd_data;
      c_ack    = ack_stb;
      c_ack_id = ack_id;
      c_eoi    = eoi_stb;
      c_eoi_id = eoi_id;
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq after reset", 32'(irq_o), 32'd0);
      bus(1'b0, A_CTRL, '0);
      chk("R1 ctrl after reset", c_rdata, 32'd0);
      bus(1'b0, A_MASK, '0);
      chk("R1 threshold after reset", c_rdata, 32'd0);
      bus(1'b0, A_ACK, '0);
      chk("R1 ack read after reset", c_rdata, SPUR);
      chk("R6 no ack strobe after reset", 32'(c_ack), 32'd0);
      chk("R11 read valid after read", 32'(c_rdv), 32'd1);

      // R2 / R3 register storage
      bus(1'b1, A_CTRL, 32'hFFFF_FFFE);
      chk("R11 no read valid after write", 32'(c_rdv), 32'd0);
      bus(1'b0, A_CTRL, '0);
      chk("R2 ctrl bit0 only (wrote 0)", c_rdata, 32'd0);
      bus(1'b1, A_CTRL, 32'hFFFF_FFFF);
      bus(1'b0, A_CTRL, '0);
      chk("R2 ctrl readback", c_rdata, 32'd1);
      bus(1'b1, A_MASK, 32'h1234_56AB);
      bus(1'b0, A_MASK, '0);
      chk("R3 threshold readback", c_rdata, 32'h0000_00AB);

      // R10 ignored write to ack offset and zero reads
      bus(1'b1, A_ACK, 32'hFFFF_FFFF);
      chk("R10 ack offset write no ack strobe", 32'(c_ack), 32'd0);
      chk("R10 ack offset write no eoi strobe", 32'(c_eoi), 32'd0);
      bus(1'b0, A_MASK, '0);
      chk("R10 threshold unchanged", c_rdata, 32'h0000_00AB);
      bus(1'b0, A_CTRL, '0);
      chk("R10 ctrl unchanged", c_rdata, 32'd1);
      bus(1'b0, A_EOI, '0);
      chk("R10 eoi offset reads 0", c_rdata, 32'd0);
      bus(1'b0, 12'h008, '0);
      chk("R10 unmapped 0x008 reads 0", c_rdata, 32'd0);
      bus(1'b0, 12'h100, '0);
      chk("R10 unmapped 0x100 reads 0", c_rdata, 32'd0);

      // table walk: R4, R5, R6, R7, R8
      for (int i = 0; i < NV; i++) begin
         logic          v_en;
         logic [7:0]    v_mask;
         logic          v_pv;
         logic [7:0]    v_prio;
         logic [9:0]    v_id;
         logic          v_exp;
         {v_en, v_mask, v_pv, v_prio, v_id, v_exp} = VEC[i];
         pend_valid = v_pv;
         pend_prio  = v_prio;
         pend_id    = v_id;
         bus(1'b1, A_CTRL, 32'(v_en));
         bus(1'b1, A_MASK, 32'(v_mask));
         @(negedge clk);
         chk($sformatf("R4 irq vec%0d", i), 32'(irq_o), 32'(v_exp));
         bus(1'b0, A_ACK, '0);
         if (v_exp) begin
            chk($sformatf("R5 ack data vec%0d", i), c_rdata, 32'(v_id));
            chk($sformatf("R5 ack strobe vec%0d", i), 32'(c_ack), 32'd1);
            chk($sformatf("R5 ack id vec%0d", i), 32'(c_ack_id), 32'(v_id));
            chk($sformatf("R7 irq low once active vec%0d", i), 32'(irq_o), 32'd0);
            pend_valid = 1'b0;
            bus(1'b1, A_EOI, 32'(v_id));
            chk($sformatf("R8 eoi strobe vec%0d", i), 32'(c_eoi), 32'd1);
            chk($sformatf("R8 eoi id vec%0d", i), 32'(c_eoi_id), 32'(v_id));
         end else begin
            chk($sformatf("R6 spurious vec%0d", i), c_rdata, SPUR);
            chk($sformatf("R6 no ack strobe vec%0d", i), 32'(c_ack), 32'd0);
         end
      end

      // R7 / R9 / R8: no preemption, wrong EOI ignored
      pend_valid = 1'b1;
      pend_prio  = 8'h10;
      pend_id    = 10'd100;
      bus(1'b1, A_CTRL, 32'd1);
      bus(1'b1, A_MASK, 32'hFF);
      @(negedge clk);
      bus(1'b0, A_ACK, '0);
      chk("R5 claim id 100", c_rdata, 32'd100);
      pend_prio = 8'h00;
      pend_id   = 10'd9;
      @(negedge clk);
      @(negedge clk);
      chk("R7 better candidate not signalled", 32'(irq_o), 32'd0);
      bus(1'b0, A_ACK, '0);
      chk("R7 ack while active is spurious", c_rdata, SPUR);
      chk("R7 no ack strobe while active", 32'(c_ack), 32'd0);
      bus(1'b1, A_EOI, 32'd9);
      chk("R9 wrong id eoi no strobe", 32'(c_eoi), 32'd0);
      @(negedge clk);
      chk("R9 still active after wrong eoi", 32'(irq_o), 32'd0);
      bus(1'b1, A_EOI, 32'd100);
      chk("R8 correct eoi strobe", 32'(c_eoi), 32'd1);
      chk("R8 correct eoi id", 32'(c_eoi_id), 32'd100);
      @(negedge clk);
      chk("R8 irq returns after eoi", 32'(irq_o), 32'd1);
      bus(1'b1, A_EOI, 32'd9);
      chk("R9 eoi with nothing active no strobe", 32'(c_eoi), 32'd0);
      bus(1'b0, A_ACK, '0);
      chk("R9 candidate still claimable", c_rdata, 32'd9);
      bus(1'b1, A_EOI, 32'd9);
      chk("R8 retire id 9", 32'(c_eoi), 32'd1);

      // R4 disable drops the line
      @(negedge clk);
      chk("R4 irq with qualifying candidate", 32'(irq_o), 32'd1);
      bus(1'b1, A_CTRL, 32'd0);
      @(negedge clk);
      chk("R4 irq low when disabled", 32'(irq_o), 32'd0);

      finish_run();
   end
endmodule